// File: doc/BRIEF.md
# Keyboard Matrix Scan Encoder

This block turns a snapshot of a six-row, sixteen-column switch matrix into a key code and a modifier status byte. A one-cycle scan request starts a pass that visits one row per clock, row 0 first. Within a row, columns are taken from bit 0 upward. Every closed switch is translated into an 8-bit code through a lookup table supplied as a parameter. Four reserved table codes mark modifier keys. Each of these sets one bit of the status byte and does not touch the key code. Any other closed switch replaces the held key code. As a result, the last ordinary key met in scan order is the one reported.

The results commit only when the last row has been processed. When the accumulated key code is nonzero, the code and status are loaded into a receive register, the ready flag is raised, and the byte selector is rewound. When the code is zero, nothing changes. The host reads the receive register through one data port. The key code and the status byte appear on alternate reads, and acknowledging the status byte drops the ready flag.

Top module: `kbd_scan_enc`

## Requirements
- R1: After reset, scan_busy and rx_ready are 0, the presented byte is the key code 0x00, and one acknowledge later the presented byte is the status 0x80.
- R2: A scan_tick seen while idle raises scan_busy for exactly NUM_ROWS (6) cycles, handling one row per cycle with row 0 first. Results are visible after the edge that ends the last row. A scan_tick seen while busy is ignored.
- R3: A closed switch at row r, column c (key_matrix bit r*16+c) is looked up at table entry r*16+c (bits [8*(r*16+c)+7 : 8*(r*16+c)]). In the default table, entry i holds i+1, except that entries 28, 41, 54 and 55 hold 0xFF, 0xFE, 0xFD and 0xFC, and entries 93 to 95 hold 0x00.
- R4: The modifier codes map to status bits as follows: 0xFE sets bit 0, 0xFF sets bit 1, 0xFC sets bit 2 and 0xFD sets bit 3. Modifiers never change the key code.
- R5: The status byte always has bit 7 set and bits 6 to 4 clear.
- R6: Every non-modifier closure overwrites the held code, including a closure whose table code is 0x00. The code reported is therefore the last such closure in scan order: rows ascending, then columns ascending.
- R7: A scan that ends with key code 0x00 leaves the stored key code, stored status, rx_ready and the byte selector unchanged.
- R8: A scan that ends with a nonzero key code stores the code and status, sets rx_ready, and rewinds the selector so that the next presented byte is the key code.
- R9: rd_data shows the key code while the selector is 0 and the status while it is 1. Each rd_ack toggles the selector. An rd_ack while the status is shown clears rx_ready.
- R10: When a committing scan and rd_ack fall on the same edge, the commit takes effect: the selector is 0 and rx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_tick | input | 1 | One-cycle scan request |
| key_matrix | input | NUM_ROWS*NUM_COLS | Switch states, row r column c at bit r*NUM_COLS+c; held stable during a scan |
| rd_ack | input | 1 | Host acknowledge; consumes the presented byte |
| rd_data | output | 8 | Presented byte: key code or status |
| rx_ready | output | 1 | A fresh code and status pair is waiting |
| scan_busy | output | 1 | A scan is in progress |

## Verification
Count the sampled scan_tick edge as edge 0. scan_busy is high after edge 0 and low again after edge 6, and the committed code, status and ready flag are visible after edge 6. The bench therefore waits exactly seven rising edges before it compares them. The read port is combinational on the selector, so the bench compares rd_data before each acknowledge and checks the next byte one edge after it. All sampling and driving happen on the falling edge, and the collision case holds rd_ack across edge 6 so that both events land on the same edge.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

   localparam int KS_CODE_W   = 8;
   localparam int KS_DEF_ROWS = 6;
   localparam int KS_DEF_COLS = 16;
   localparam int KS_MOD_W    = 4;

   localparam logic [KS_CODE_W-1:0] KS_MOD_CAPS  = 8'hFF;
   localparam logic [KS_CODE_W-1:0] KS_MOD_SHIFT = 8'hFE;
   localparam logic [KS_CODE_W-1:0] KS_MOD_ALT   = 8'hFD;
   localparam logic [KS_CODE_W-1:0] KS_MOD_CTRL  = 8'hFC;
   localparam logic [KS_CODE_W-1:0] KS_STATUS_BASE = 8'h80;

   // modifier code to its status bit (bits 3:0 of the status byte)
   function automatic logic [KS_MOD_W-1:0] ks_mod_bit(input logic [KS_CODE_W-1:0] code);
      logic [KS_MOD_W-1:0] m;
      case (code)
         KS_MOD_SHIFT: m = 4'b0001;
         KS_MOD_CAPS:  m = 4'b0010;
         KS_MOD_CTRL:  m = 4'b0100;
         KS_MOD_ALT:   m = 4'b1000;
         default:      m = 4'b0000;
      endcase
      return m;
   endfunction

   // computed default lookup table for the 6x16 matrix
   function automatic logic [KS_DEF_ROWS*KS_DEF_COLS*KS_CODE_W-1:0] ks_default_table();
      logic [KS_DEF_ROWS*KS_DEF_COLS*KS_CODE_W-1:0] t;
      t = '0;
      for (int i = 0; i < KS_DEF_ROWS*KS_DEF_COLS; i++) begin
         logic [KS_CODE_W-1:0] v;
         if (i == 28)      v = KS_MOD_CAPS;
         else if (i == 41) v = KS_MOD_SHIFT;
         else if (i == 54) v = KS_MOD_ALT;
         else if (i == 55) v = KS_MOD_CTRL;
         else if (i >= 93) v = '0;
         else              v = KS_CODE_W'(i + 1);
         t[i*KS_CODE_W +: KS_CODE_W] = v;
      end
      return t;
   endfunction

endpackage

// File: rtl/kbd_row_decode.sv
module kbd_row_decode
   import kbd_scan_pkg::*;
#(
   parameter int NUM_COLS = 16,
   parameter int CODE_W   = 8
) (
   input  logic [NUM_COLS-1:0]        row_bits,
   input  logic [NUM_COLS*CODE_W-1:0] row_codes,
   output logic                       row_hit,
   output logic [CODE_W-1:0]          row_code,
   output logic [KS_MOD_W-1:0]        row_mods
);

   logic [KS_MOD_W-1:0] col_mod [NUM_COLS];
   logic [NUM_COLS-1:0] col_key;
   logic [CODE_W-1:0]   col_code [NUM_COLS];

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      logic [KS_MOD_W-1:0] mb;
      assign col_code[c] = row_codes[c*CODE_W +: CODE_W];
      assign mb          = ks_mod_bit(col_code[c]);
      assign col_mod[c]  = row_bits[c] ? mb : '0;
      assign col_key[c]  = row_bits[c] && (mb == '0);
   end

   // columns ascend; a later ordinary closure overrides an earlier one
   always_comb begin
      row_hit  = 1'b0;
      row_code = '0;
      row_mods = '0;
      for (int c = 0; c < NUM_COLS; c++) begin
         row_mods = row_mods | col_mod[c];
         if (col_key[c]) begin
            row_hit  = 1'b1;
            row_code = col_code[c];
         end
      end
   end

endmodule

// File: rtl/kbd_scan_seq.sv
module kbd_scan_seq
   import kbd_scan_pkg::*;
#(
   parameter int NUM_ROWS  = 6,
   parameter int CODE_W    = 8,
   parameter int ROW_IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scan_tick,
   input  logic                 row_hit,
   input  logic [CODE_W-1:0]    row_code,
   input  logic [KS_MOD_W-1:0]  row_mods,
   output logic                 busy,
   output logic [ROW_IDX_W-1:0] row_idx,
   output logic                 commit,
   output logic [CODE_W-1:0]    commit_code,
   output logic [CODE_W-1:0]    commit_status
);

   localparam logic [ROW_IDX_W-1:0] LAST_ROW = ROW_IDX_W'(NUM_ROWS - 1);

   logic [CODE_W-1:0]   acc_code;
   logic [KS_MOD_W-1:0] acc_mods;
   logic [CODE_W-1:0]   mrg_code;
   logic [KS_MOD_W-1:0] mrg_mods;
   logic                last_row;

   assign mrg_code = row_hit ? row_code : acc_code;
   assign mrg_mods = acc_mods | row_mods;
   assign last_row = busy && (row_idx == LAST_ROW);

   assign commit        = last_row && (mrg_code != '0);
   assign commit_code   = mrg_code;
   assign commit_status = KS_STATUS_BASE | CODE_W'(mrg_mods);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         row_idx  <= '0;
         acc_code <= '0;
         acc_mods <= '0;
      end else if (!busy) begin
         if (scan_tick) begin
            busy     <= 1'b1;
            row_idx  <= '0;
            acc_code <= '0;
            acc_mods <= '0;
         end
      end else if (last_row) begin
         busy    <= 1'b0;
         row_idx <= '0;
      end else begin
         row_idx  <= row_idx + 1'b1;
         acc_code <= mrg_code;
         acc_mods <= mrg_mods;
      end
   end

endmodule

// File: rtl/kbd_rx_port.sv
module kbd_rx_port
   import kbd_scan_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [CODE_W-1:0] commit_code,
   input  logic [CODE_W-1:0] commit_status,
   input  logic              rd_ack,
   output logic [CODE_W-1:0] rd_data,
   output logic              rx_ready,
   output logic [CODE_W-1:0] status_q,
   output logic              sel_q
);

   logic [CODE_W-1:0] key_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q    <= '0;
         status_q <= KS_STATUS_BASE;
         rx_ready <= 1'b0;
         sel_q    <= 1'b0;
      end else if (commit) begin
         key_q    <= commit_code;
         status_q <= commit_status;
         rx_ready <= 1'b1;
         sel_q    <= 1'b0;
      end else if (rd_ack) begin
         sel_q <= ~sel_q;
         if (sel_q) rx_ready <= 1'b0;
      end
   end

   assign rd_data = sel_q ? status_q : key_q;

endmodule

// File: rtl/kbd_scan_enc.sv
module kbd_scan_enc
   import kbd_scan_pkg::*;
#(
   parameter int NUM_ROWS = KS_DEF_ROWS,
   parameter int NUM_COLS = KS_DEF_COLS,
   parameter int CODE_W   = KS_CODE_W,
   parameter logic [NUM_ROWS*NUM_COLS*CODE_W-1:0] CODE_TABLE = ks_default_table()
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         scan_tick,
   input  logic [NUM_ROWS*NUM_COLS-1:0] key_matrix,
   input  logic                         rd_ack,
   output logic [CODE_W-1:0]            rd_data,
   output logic                         rx_ready,
   output logic                         scan_busy
);

   localparam int ROW_IDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
   localparam int ROW_CODE_BITS = NUM_COLS * CODE_W;

   if (NUM_ROWS < 1) begin : g_bad_rows
      $error("kbd_scan_enc: NUM_ROWS must be at least 1");
   end
   if (NUM_COLS < 1) begin : g_bad_cols
      $error("kbd_scan_enc: NUM_COLS must be at least 1");
   end
   if (CODE_W != KS_CODE_W) begin : g_bad_code
      $error("kbd_scan_enc: CODE_W must match the 8-bit modifier codes");
   end

   logic [ROW_IDX_W-1:0]     row_idx;
   logic [NUM_COLS-1:0]      row_bits;
   logic [ROW_CODE_BITS-1:0] row_codes;
   logic                     row_hit;
   logic [CODE_W-1:0]        row_code;
   logic [KS_MOD_W-1:0]      row_mods;
   logic                     commit;
   logic [CODE_W-1:0]        commit_code;
   logic [CODE_W-1:0]        commit_status;
   logic [CODE_W-1:0]        status_w;
   logic                     sel_w;

   assign row_bits  = key_matrix[int'(row_idx)*NUM_COLS +: NUM_COLS];
   assign row_codes = CODE_TABLE[int'(row_idx)*ROW_CODE_BITS +: ROW_CODE_BITS];

   kbd_row_decode #(.NUM_COLS(NUM_COLS), .CODE_W(CODE_W)) u_row (
      .row_bits  (row_bits),
      .row_codes (row_codes),
      .row_hit   (row_hit),
      .row_code  (row_code),
      .row_mods  (row_mods)
   );

   kbd_scan_seq #(.NUM_ROWS(NUM_ROWS), .CODE_W(CODE_W), .ROW_IDX_W(ROW_IDX_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .scan_tick     (scan_tick),
      .row_hit       (row_hit),
      .row_code      (row_code),
      .row_mods      (row_mods),
      .busy          (scan_busy),
      .row_idx       (row_idx),
      .commit        (commit),
      .commit_code   (commit_code),
      .commit_status (commit_status)
   );

   kbd_rx_port #(.CODE_W(CODE_W)) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .commit        (commit),
      .commit_code   (commit_code),
      .commit_status (commit_status),
      .rd_ack        (rd_ack),
      .rd_data       (rd_data),
      .rx_ready      (rx_ready),
      .status_q      (status_w),
      .sel_q         (sel_w)
   );

endmodule

// File: rtl/kbd_scan_chk.sv
module kbd_scan_chk #(
   parameter int NUM_ROWS = 6
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scan_busy,
   input logic       rx_ready,
   input logic       rd_ack,
   input logic [7:0] status_w,
   input logic       sel_w
);

   int unsigned run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_cnt <= 0;
      else if (scan_busy) run_cnt <= run_cnt + 1;
      else                run_cnt <= 0;
   end

   AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy |-> run_cnt < NUM_ROWS); // R2

   AST_SCAN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_busy) |-> $past(run_cnt) == NUM_ROWS - 1); // R2

   AST_STATUS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      status_w[7] && (status_w[6:4] == 3'b000)); // R5

   AST_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ready) |-> $past(scan_busy)); // R8

   AST_READY_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ready) |-> !sel_w); // R8

   AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_ready) |-> ($past(rd_ack) && $past(sel_w))); // R9

endmodule

bind kbd_scan_enc kbd_scan_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scan_busy (scan_busy),
   .rx_ready  (rx_ready),
   .rd_ack    (rd_ack),
   .status_w  (status_w),
   .sel_w     (sel_w)
);

// File: tb/kbd_scan_enc_tb_top.sv
module kbd_scan_enc_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scan_tick = 1'b0;
   logic        rd_ack = 1'b0;
   logic [95:0] mat = '0;
   logic [7:0]  rd_data;
   logic        rx_ready;
   logic        scan_busy;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_key = 8'h00;
   logic [7:0] exp_st  = 8'h80;
   logic       exp_rdy = 1'b0;
   logic       exp_sel = 1'b0;

   always #10 clk = ~clk;

   kbd_scan_enc dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_tick  (scan_tick),
      .key_matrix (mat),
      .rd_ack     (rd_ack),
      .rd_data    (rd_data),
      .rx_ready   (rx_ready),
      .scan_busy  (scan_busy)
   );

   // default table, from R3
   function automatic logic [7:0] tb_code(int r, int c);
      int i = r * 16 + c;
      if (i == 28) return 8'hFF;
      if (i == 41) return 8'hFE;
      if (i == 54) return 8'hFD;
      if (i == 55) return 8'hFC;
      if (i >= 93) return 8'h00;
      return 8'(i + 1);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // model of one scan and its commit (R4 R5 R6 R7 R8)
   task automatic model_scan(logic [95:0] m);
      logic [7:0] code = 8'h00;
      logic [7:0] st = 8'h80;
      for (int r = 0; r < 6; r++)
         for (int c = 0; c < 16; c++)
            if (m[r*16+c]) begin
               logic [7:0] v = tb_code(r, c);
               case (v)
                  8'hFE: st[0] = 1'b1;
                  8'hFF: st[1] = 1'b1;
                  8'hFC: st[2] = 1'b1;
                  8'hFD: st[3] = 1'b1;
                  default: code = v;
               endcase
            end
      if (code != 8'h00) begin
         exp_key = code;
         exp_st  = st;
         exp_rdy = 1'b1;
         exp_sel = 1'b0;
      end
   endtask

   task automatic run_scan(string req, logic [95:0] m, bit ack_last);
      mat = m;
      scan_tick = 1'b1;
      step();
      scan_tick = 1'b0;
      chk("R2 busy after start", 32'(scan_busy), 32'd1);
      repeat (5) step();
      chk("R2 busy in last row", 32'(scan_busy), 32'd1);
      rd_ack = ack_last;
      step();
      rd_ack = 1'b0;
      model_scan(m);
      chk("R2 busy ends", 32'(scan_busy), 32'd0);
      chk({req, " ready"}, 32'(rx_ready), 32'(exp_rdy));
      chk({req, " data"}, 32'(rd_data), 32'(exp_sel ? exp_st : exp_key));
   endtask

   task automatic do_read(string req);
      chk({req, " byte"}, 32'(rd_data), 32'(exp_sel ? exp_st : exp_key));
      rd_ack = 1'b1;
      step();
      rd_ack = 1'b0;
      if (exp_sel) exp_rdy = 1'b0;
      exp_sel = ~exp_sel;
      chk({req, " ready after ack"}, 32'(rx_ready), 32'(exp_rdy));
   endtask

   function automatic logic [95:0] bit_at(int r, int c);
      logic [95:0] v = '0;
      v[r*16+c] = 1'b1;
      return v;
   endfunction

   initial begin
      #(20 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy", 32'(scan_busy), 32'd0);
      chk("R1 ready", 32'(rx_ready), 32'd0);
      do_read("R1 key");
      chk("R1 status", 32'(rd_data), 32'h80);
      do_read("R1 status");

      // R3 R8 single key at row 0 col 0
      run_scan("R3 R8 single", bit_at(0, 0), 1'b0);
      chk("R8 code", 32'(rd_data), 32'h01);
      do_read("R9 key");
      do_read("R9 status");
      chk("R9 ready cleared", 32'(rx_ready), 32'd0);

      // R4 R5 all modifiers plus key row 4 col 5 (code 70)
      run_scan("R4 mods", bit_at(1,12) | bit_at(2,9) | bit_at(3,6) | bit_at(3,7) | bit_at(4,5), 1'b0);
      chk("R4 code", 32'(rd_data), 32'd70);
      do_read("R4 key");
      chk("R4 R5 status", 32'(rd_data), 32'h8F);
      do_read("R4 status");

      // R4 shift alone with key
      run_scan("R4 shift", bit_at(2,9) | bit_at(0,1), 1'b0);
      do_read("R4 key2");
      chk("R4 shift status", 32'(rd_data), 32'h81);
      do_read("R4 status2");

      // R6 last in scan order wins, across and within rows
      run_scan("R6 order", bit_at(0,3) | bit_at(1,15) | bit_at(2,0), 1'b0);
      chk("R6 cross row", 32'(rd_data), 32'd33);
      do_read("R6 key");
      do_read("R6 status");
      run_scan("R6 within", bit_at(1,2) | bit_at(1,10), 1'b0);
      chk("R6 within row", 32'(rd_data), 32'd27);
      do_read("R6 key2");
      do_read("R6 status2");

      // R6 R7 zero-code key last erases result; nothing changes
      run_scan("R7 zero overwrite", bit_at(0,0) | bit_at(5,14), 1'b0);
      chk("R7 ready kept", 32'(rx_ready), 32'd0);
      chk("R7 key kept", 32'(rd_data), 32'd27);
      do_read("R7 key");
      chk("R7 status kept", 32'(rd_data), 32'h80);
      // modifiers only, selector on status: remains unchanged
      run_scan("R7 mods only", bit_at(3,7) | bit_at(1,12), 1'b0);
      chk("R7 status unchanged", 32'(rd_data), 32'h80);
      do_read("R7 status");

      // R2 tick during scan ignored
      mat = bit_at(4,0);
      scan_tick = 1'b1;
      step();
      scan_tick = 1'b0;
      step();
      scan_tick = 1'b1;
      step();
      scan_tick = 1'b0;
      repeat (4) step();
      model_scan(bit_at(4,0));
      chk("R2 ignored tick busy", 32'(scan_busy), 32'd0);
      step();
      chk("R2 no restart", 32'(scan_busy), 32'd0);
      chk("R2 result", 32'(rd_data), 32'd65);

      // R10 commit and ack on the same edge
      do_read("R10 pre key");
      run_scan("R10 collision", bit_at(3,3), 1'b1);
      chk("R10 sel rewound", 32'(rd_data), 32'd52);
      chk("R10 ready", 32'(rx_ready), 32'd1);
      do_read("R10 key");
      do_read("R10 status");

      // random mix
      for (int n = 0; n < 40; n++) begin
         logic [95:0] m = '0;
         int k = $urandom % 5;
         for (int j = 0; j < k; j++) m[$urandom % 96] = 1'b1;
         run_scan("R6 R8 random", m, 1'b0);
         for (int j = 0; j < int'($urandom % 3); j++) do_read("R9 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule